// File: doc/BRIEF.md
# Debug-aware memory access cycle counter

This block counts the memory access cycles of a processor core and leaves out the cycles spent while the core is halted for debug. It watches two per-cycle inputs: a debug acknowledge level from the core and a strobe that marks cycles carrying a memory access. When the acknowledge goes high, the count stops one cycle later than the edge. This is because the core still performs one last access in the cycle after the rise. When the acknowledge falls, counting starts again in the next cycle, which carries the first access the counter has not yet seen.

A system-speed access made from debug can briefly pull the acknowledge low. Peripherals that depend on the access count must not see such an access. For this case, software can set a configuration bit that holds the acknowledge seen by the counter high, whatever the input does. The count is readable at all times. A synchronous clear sets it back to zero.

Top module: `dbgcnt_top`

## Requirements
- R1: While reset is asserted and after its release, the count reads 0 and the force bit reads 0. The first strobed cycle after reset is counted.
- R2: In a cycle with the access strobe high, no clear, and counting enabled, the count rises by exactly one. The new value is visible after the clock edge of that cycle.
- R3: In a cycle with the access strobe low and no clear, the count holds its value.
- R4: A clear cycle sets the count to 0, even when the access strobe is high in that cycle.
- R5: The count wraps from all ones to 0 on the next counted access. With a 6-bit count, 64 counted accesses after a clear return it to 0.
- R6: Let the effective acknowledge rise in cycle t and stay high. Accesses in cycles t and t+1 are counted. Accesses from cycle t+2 onward are not counted while it stays high.
- R7: Let the effective acknowledge fall in cycle t after at least two high cycles. An access in cycle t is not counted. Accesses from cycle t+1 onward are counted.
- R8: A cycle with the configuration write enable high loads the force bit from the write data. The force bit reads back the loaded value from the next cycle on.
- R9: While the force bit is 1, the effective acknowledge is 1 whatever the acknowledge input does. After the bit has been 1 for two cycles, no access is counted, even while the input is low.
- R10: An effective acknowledge that is high for a single cycle does not stop counting in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| dbg_ack_i | input | 1 | Debug acknowledge level from the core |
| mem_acc_i | input | 1 | High in cycles that carry a memory access |
| cnt_clr_i | input | 1 | Synchronous clear of the count |
| cfg_we_i | input | 1 | Write enable for the force bit |
| cfg_force_wdata_i | input | 1 | Value written to the force bit |
| cfg_force_o | output | 1 | Current force bit |
| count_o | output | CNT_W | Current count |

## Verification
The assertions check the following on every cycle:
- The count is cleared, advanced by one, or held, according to the clear and strobe inputs.
- The enable drops after two consecutive high cycles of the effective acknowledge and returns the cycle after a low one.
- The force bit takes the value written to it.

Only the bench scenarios show the following:
- The exact count gained across a debug entry and exit window.
- That a single-cycle acknowledge pulse leaves no gap.
- That a forced acknowledge hides low pulses on the input.
- That the count wraps.

// File: rtl/dbgcnt_pkg.sv
package dbgcnt_pkg;
  // Default count width
  localparam int unsigned DBGCNT_W_DEF = 32;
  // Number of consecutive effective-acknowledge cycles before counting stops
  localparam int unsigned DBGCNT_HALT_LAG = 2;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'b00,
    CNT_INCR  = 2'b01,
    CNT_CLEAR = 2'b10
  } cnt_op_e;
endpackage

// File: rtl/dbgcnt_cfg_reg.sv
module dbgcnt_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic wdata_i,
  output logic force_o
);
  logic force_q;
  logic force_d;

  always_comb begin
    force_d = force_q;
    if (we_i) force_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= force_d;
  end

  assign force_o = force_q;

  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (force_o == $past(wdata_i))); // R8
  AST_FORCE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(force_o)); // R8
endmodule

// File: rtl/dbgcnt_gate.sv
module dbgcnt_gate
  import dbgcnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic force_i,
  output logic en_o
);
  localparam int unsigned LAG = DBGCNT_HALT_LAG;

  logic           ack_eff;
  logic [LAG-1:0] hist_q;
  logic [LAG-1:0] hist_d;

  assign ack_eff = ack_i | force_i;

  // History shift register: one stage per cycle of lag
  generate
    if (LAG == 1) begin : g_one
      always_comb hist_d = ack_eff;
    end else begin : g_many
      always_comb hist_d = {hist_q[LAG-2:0], ack_eff};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // Counting stops only once every tracked cycle saw the acknowledge
  assign en_o = ~(&hist_q);

  // Cycles since reset, saturating, so history-based checks never look before reset
  logic [1:0] age_q;
  logic [1:0] age_d;
  always_comb begin
    age_d = age_q;
    if (age_q != 2'd3) age_d = age_q + 2'd1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else        age_q <= age_d;
  end

  AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_eff |=> en_o); // R7
  AST_HALT_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n || age_q == 2'd0)
    (ack_eff && $past(ack_eff)) |=> !en_o); // R6
  AST_FORCE_HIDES: assert property (@(posedge clk) disable iff (!rst_n || age_q == 2'd0)
    (force_i && $past(force_i)) |=> !en_o); // R9
endmodule

// File: rtl/dbgcnt_counter.sv
module dbgcnt_counter
  import dbgcnt_pkg::*;
#(
  parameter int unsigned CNT_W = DBGCNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr_i)              op = CNT_CLEAR;
    else if (acc_i && en_i) op = CNT_INCR;
    else                    op = CNT_HOLD;
  end

  always_comb begin
    unique case (op)
      CNT_CLEAR: cnt_d = '0;
      CNT_INCR:  cnt_d = cnt_q + ONE;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && acc_i && en_i) |=> (cnt_o == CNT_W'($past(cnt_o) + ONE))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !acc_i) |=> $stable(cnt_o)); // R3
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(cnt_o)); // R6
endmodule

// File: rtl/dbgcnt_top.sv
module dbgcnt_top
  import dbgcnt_pkg::*;
#(
  parameter int unsigned CNT_W = DBGCNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_ack_i,
  input  logic             mem_acc_i,
  input  logic             cnt_clr_i,
  input  logic             cfg_we_i,
  input  logic             cfg_force_wdata_i,
  output logic             cfg_force_o,
  output logic [CNT_W-1:0] count_o
);
  logic force_bit;
  logic cnt_en;

  dbgcnt_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_force_wdata_i),
    .force_o (force_bit)
  );

  dbgcnt_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_i   (dbg_ack_i),
    .force_i (force_bit),
    .en_o    (cnt_en)
  );

  dbgcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr_i),
    .acc_i (mem_acc_i),
    .en_i  (cnt_en),
    .cnt_o (count_o)
  );

  assign cfg_force_o = force_bit;

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (count_o == '0 && cfg_force_o == 1'b0)); // R1
endmodule

// File: tb/tb_dbgcnt_top.sv
module tb_dbgcnt_top;
  localparam int unsigned W = 6;
  localparam int unsigned MOD = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 1'b0, acc = 1'b0, clr = 1'b0, we = 1'b0, wd = 1'b0;
  logic force_o;
  logic [W-1:0] count;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0;
  bit m_force = 0, m_h1 = 0, m_h2 = 0;
  bit m_en;

  dbgcnt_top #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .dbg_ack_i(ack), .mem_acc_i(acc),
    .cnt_clr_i(clr), .cfg_we_i(we), .cfg_force_wdata_i(wd),
    .cfg_force_o(force_o), .count_o(count)
  );

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model, compared on every clock
  always @(posedge clk) begin
    if (rst_n) begin
      m_en = !(m_h1 && m_h2);
      if (clr) m_cnt = 0;
      else if (acc && m_en) m_cnt = (m_cnt + 1) % MOD;
      m_h2 = m_h1;
      m_h1 = ack || m_force;
      if (we) m_force = wd;
      #2;
      check(cur_req, int'(count), m_cnt);
      check(cur_req, int'(force_o), int'(m_force));
    end
  end

  task automatic step(bit a, bit s, bit c = 0, bit w = 0, bit d = 0);
    @(negedge clk);
    ack = a; acc = s; clr = c; we = w; wd = d;
  endtask

  task automatic settle();
    @(negedge clk);
    ack = 0; acc = 0; clr = 0; we = 0; wd = 0;
  endtask

  int base;

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(count), 0);
    check("R1", int'(force_o), 0);
    rst_n = 1'b1;
    // R1: first strobe after reset counts
    cur_req = "R1";
    step(0, 1); settle();
    check("R1", int'(count), 1);

    // R2 / R3: mixed strobe pattern
    cur_req = "R2";
    for (int i = 0; i < 12; i++) step(0, (i % 3) != 1);
    settle();
    check("R2", int'(count), 9);
    cur_req = "R3";
    for (int i = 0; i < 4; i++) step(0, 0);
    settle();
    check("R3", int'(count), 9);

    // R4: clear wins over strobe
    cur_req = "R4";
    step(0, 1, 1); settle();
    check("R4", int'(count), 0);

    // R6 / R7: ack high cycles 0..5, low 6..9, strobe every cycle
    cur_req = "R6";
    base = int'(count);
    for (int i = 0; i < 6; i++) step(1, 1);
    cur_req = "R7";
    for (int i = 0; i < 4; i++) step(0, 1);
    settle();
    check("R6", int'(count) - base, 5);

    // R10: single-cycle pulse leaves no gap
    cur_req = "R10";
    base = int'(count);
    step(1, 1);
    for (int i = 0; i < 4; i++) step(0, 1);
    settle();
    check("R10", int'(count) - base, 5);

    // R8 / R9: force set, input pulses low are hidden
    cur_req = "R8";
    step(0, 0, 0, 1, 1); settle();
    check("R8", int'(force_o), 1);
    step(0, 0);
    cur_req = "R9";
    base = int'(count);
    for (int i = 0; i < 8; i++) step(i[0], 1);
    settle();
    check("R9", int'(count) - base, 0);
    cur_req = "R8";
    step(0, 0, 0, 1, 0); settle();
    check("R8", int'(force_o), 0);
    step(0, 0); step(0, 0);
    base = int'(count);
    for (int i = 0; i < 3; i++) step(0, 1);
    settle();
    check("R9", int'(count) - base, 3);

    // R5: wrap
    cur_req = "R5";
    step(0, 0, 1);
    for (int i = 0; i < MOD; i++) step(0, 1);
    settle();
    check("R5", int'(count), 0);
    step(0, 1); settle();
    check("R5", int'(count), 1);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule